// File: doc/BRIEF.md
# Frame Header Obfuscation Datapath

This block sits between the frame buffer of a time-triggered bus controller and its byte encoder/decoder. It turns a frame, presented as a series of 64-bit blocks, into ciphertext on transmit and back into plaintext on receive. The first block of every frame is the header block. Its flag byte travels beside the block in clear, so that startup and synchronisation logic downstream can still read it. The other four header bytes (slot, cycle, payload length, header CRC) share that block with a 32-bit timestamp and are enciphered under the pre-shared key. Each following payload block is enciphered under a per-frame key that folds the timestamp into the pre-shared key. An observer without the key therefore sees neither the schedule fields nor repeated payload patterns.

A pulse on `frame_start` marks a frame boundary. It captures the direction, the padding option, the two round counts and the key for the frame. It also makes the next accepted block the header block. Blocks enter through a valid/ready port and wait in a one-entry prefetch register while the cipher engine is busy. The engine does one round per clock. Results leave through a registered valid/ready port. On receive, the timestamp recovered from the decrypted header rebuilds the payload key.

Top module: `hdr_obf_dp`

## Requirements
- R1: The 8-bit flag that accompanies each block appears unchanged on `out_flag` next to that block's result, in both directions. `out_hdr` is 1 only for the header block.
- R2: The header block is laid out as `in_data[63:32]` = four header bytes and `in_data[31:0]` = timestamp. On transmit it is enciphered with the frame's pre-shared key and the header round count.
- R3: Cipher with N rounds, key register K (80 bits) and state s (64 bits). For r = 1..N: s = P(S(s xor K[79:16])), then K is rotated left by 61, its top nibble is passed through S, and K[23:15] is XORed with r (9 bits). The result is s xor K[79:16]. S maps nibbles 0..F to C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2. P moves bit i to bit (16*i mod 63), and bit 63 stays in place.
- R4: Payload blocks use the key `psk xor {48'b0, ts}`, where ts is the frame timestamp, and the payload round count.
- R5: A round count of 0 selects 8 rounds. A header count above 32 is clamped to 32 and a payload count above 482 is clamped to 482.
- R6: On transmit, pad code 1 replaces payload bits [15:0] with ts[15:0] and pad code 2 replaces bits [31:0] with ts before enciphering. Codes 0 and 3 leave the block alone. On receive, padding has no effect.
- R7: On receive, the header block is deciphered with the pre-shared key and leaves as plaintext. Payload blocks are deciphered with the key rebuilt from the recovered timestamp.
- R8: After `frame_start`, the next accepted block is the header block and later blocks are payload. Direction, pad code, round counts and key are taken only at `frame_start`, so changes at other times have no effect.
- R9: While the engine works on a block, the prefetch register accepts the next block before the current result is available.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_flag` and `out_hdr` stay stable.
- R11: After reset `out_valid` is 0, `in_ready` is 1, and the first accepted block is treated as a header block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Frame boundary pulse; samples configuration |
| cfg_decrypt | input | 1 | 1 = receive (decipher), 0 = transmit |
| cfg_pad | input | 2 | Payload timestamp padding code (transmit) |
| cfg_hdr_rounds | input | 6 | Header round count (0 = default) |
| cfg_pay_rounds | input | 10 | Payload round count (0 = default) |
| psk | input | 80 | Pre-shared key |
| in_valid | input | 1 | Input block valid |
| in_ready | output | 1 | Prefetch register free |
| in_flag | input | 8 | Flag byte travelling with the block |
| in_data | input | 64 | Input block |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result accepted |
| out_flag | output | 8 | Flag byte of the result |
| out_hdr | output | 1 | Result is the header block |
| out_data | output | 64 | Result block |

## Verification
Transmit frames are tried with the default round counts, with clamped counts and with every pad code. A mismatch then shows whether the header-key path, the round clamp or the padding mux is wrong. Receive frames are built by enciphering known plaintext in the bench. Recovering that plaintext separates a correct inverse round from a wrong rebuilt payload key. It also shows that padding is ignored on receive. Further directed sequences cover the following:
- configuration changes made between frame pulses, which must not take effect;
- a prefetch taken while a 32-round header is still in the engine;
- an output stall of several cycles.

// File: rtl/hobf_pkg.sv
package hobf_pkg;

  localparam int BLK_W    = 64;
  localparam int KEY_W    = 80;
  localparam int TS_W     = 32;
  localparam int FLAG_W   = 8;
  localparam int RC_INJ_W = 9;

  typedef enum logic [1:0] {
    CORE_IDLE = 2'd0,
    CORE_EXP  = 2'd1,
    CORE_RUN  = 2'd2,
    CORE_DONE = 2'd3
  } core_state_t;

  localparam logic [1:0] PAD_TWO  = 2'd1;
  localparam logic [1:0] PAD_FOUR = 2'd2;

  function automatic logic [3:0] sbox4(input logic [3:0] x);
    case (x)
      4'h0: sbox4 = 4'hC;  4'h1: sbox4 = 4'h5;  4'h2: sbox4 = 4'h6;  4'h3: sbox4 = 4'hB;
      4'h4: sbox4 = 4'h9;  4'h5: sbox4 = 4'h0;  4'h6: sbox4 = 4'hA;  4'h7: sbox4 = 4'hD;
      4'h8: sbox4 = 4'h3;  4'h9: sbox4 = 4'hE;  4'hA: sbox4 = 4'hF;  4'hB: sbox4 = 4'h8;
      4'hC: sbox4 = 4'h4;  4'hD: sbox4 = 4'h7;  4'hE: sbox4 = 4'h1;  default: sbox4 = 4'h2;
    endcase
  endfunction

  // inverse found by search over the forward table
  function automatic logic [3:0] inv_sbox4(input logic [3:0] y);
    inv_sbox4 = 4'h0;
    for (int v = 0; v < 16; v++)
      if (sbox4(4'(v)) == y) inv_sbox4 = 4'(v);
  endfunction

  function automatic logic [BLK_W-1:0] sub_layer(input logic [BLK_W-1:0] x);
    for (int i = 0; i < BLK_W/4; i++) sub_layer[4*i +: 4] = sbox4(x[4*i +: 4]);
  endfunction

  function automatic logic [BLK_W-1:0] inv_sub_layer(input logic [BLK_W-1:0] x);
    for (int i = 0; i < BLK_W/4; i++) inv_sub_layer[4*i +: 4] = inv_sbox4(x[4*i +: 4]);
  endfunction

  function automatic int perm_pos(input int i);
    perm_pos = (i == BLK_W-1) ? i : (i * 16) % (BLK_W-1);
  endfunction

  function automatic logic [BLK_W-1:0] perm_layer(input logic [BLK_W-1:0] x);
    for (int i = 0; i < BLK_W; i++) perm_layer[perm_pos(i)] = x[i];
  endfunction

  function automatic logic [BLK_W-1:0] inv_perm_layer(input logic [BLK_W-1:0] x);
    for (int i = 0; i < BLK_W; i++) inv_perm_layer[i] = x[perm_pos(i)];
  endfunction

  // forward key step for round r
  function automatic logic [KEY_W-1:0] key_step(input logic [KEY_W-1:0] k,
                                                input logic [RC_INJ_W-1:0] r);
    logic [KEY_W-1:0] t;
    t = {k[18:0], k[79:19]};
    t[79:76] = sbox4(t[79:76]);
    t[23:15] = t[23:15] ^ r;
    key_step = t;
  endfunction

  // undoes key_step for the same round r
  function automatic logic [KEY_W-1:0] key_unstep(input logic [KEY_W-1:0] k,
                                                  input logic [RC_INJ_W-1:0] r);
    logic [KEY_W-1:0] t;
    t = k;
    t[23:15] = t[23:15] ^ r;
    t[79:76] = inv_sbox4(t[79:76]);
    key_unstep = {t[60:0], t[79:61]};
  endfunction

endpackage

// File: rtl/hobf_prefetch_buf.sv
module hobf_prefetch_buf #(
  parameter int W = 73
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic         full,
  output logic [W-1:0] dout
);

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      dout <= '0;
    end else if (push) begin
      full <= 1'b1;
      dout <= din;
    end else if (pop) begin
      full <= 1'b0;
    end
  end

  // a waiting block is neither lost nor altered until the engine takes it
  p_prefetch_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (full && !pop) |=> (full && $stable(dout)));

endmodule

// File: rtl/hobf_cipher_core.sv
module hobf_cipher_core
  import hobf_pkg::*;
#(
  parameter int RW         = 9,
  parameter int MAX_ROUNDS = 482,
  parameter int SIDE_W     = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              dec,
  input  logic [RW-1:0]     nrounds,
  input  logic [KEY_W-1:0]  key,
  input  logic [BLK_W-1:0]  blk,
  input  logic [SIDE_W-1:0] side,
  output logic              idle,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [BLK_W-1:0]  res_data,
  output logic [SIDE_W-1:0] res_side
);

  localparam logic [RW-1:0] ONE = RW'(1);

  core_state_t       st_q;
  logic [BLK_W-1:0]  s_q;
  logic [KEY_W-1:0]  k_q;
  logic [RW-1:0]     r_q;
  logic [RW-1:0]     n_q;
  logic              dec_q;
  logic [SIDE_W-1:0] side_q;

  logic [KEY_W-1:0]  k_fwd, k_bwd;
  logic [BLK_W-1:0]  enc_nxt, dec_nxt;

  always_comb begin
    k_fwd   = key_step(k_q, RC_INJ_W'(r_q));
    k_bwd   = key_unstep(k_q, RC_INJ_W'(r_q));
    enc_nxt = perm_layer(sub_layer(s_q ^ k_q[KEY_W-1:KEY_W-BLK_W]));
    dec_nxt = inv_sub_layer(inv_perm_layer(s_q)) ^ k_bwd[KEY_W-1:KEY_W-BLK_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= CORE_IDLE;
      s_q    <= '0;
      k_q    <= '0;
      r_q    <= '0;
      n_q    <= '0;
      dec_q  <= 1'b0;
      side_q <= '0;
    end else begin
      case (st_q)
        CORE_IDLE: if (start) begin
          s_q    <= blk;
          k_q    <= key;
          n_q    <= nrounds;
          r_q    <= ONE;
          dec_q  <= dec;
          side_q <= side;
          st_q   <= dec ? CORE_EXP : CORE_RUN;
        end
        CORE_EXP: begin
          // walk the schedule forward to the last round key
          k_q <= k_fwd;
          if (r_q == n_q) begin
            s_q  <= s_q ^ k_fwd[KEY_W-1:KEY_W-BLK_W];
            st_q <= CORE_RUN;
          end else begin
            r_q <= r_q + ONE;
          end
        end
        CORE_RUN: begin
          if (!dec_q) begin
            k_q <= k_fwd;
            if (r_q == n_q) begin
              s_q  <= enc_nxt ^ k_fwd[KEY_W-1:KEY_W-BLK_W];
              st_q <= CORE_DONE;
            end else begin
              s_q <= enc_nxt;
              r_q <= r_q + ONE;
            end
          end else begin
            k_q <= k_bwd;
            s_q <= dec_nxt;
            if (r_q == ONE) st_q <= CORE_DONE;
            else            r_q  <= r_q - ONE;
          end
        end
        default: if (res_ready) st_q <= CORE_IDLE;
      endcase
    end
  end

  assign idle      = (st_q == CORE_IDLE);
  assign res_valid = (st_q == CORE_DONE);
  assign res_data  = s_q;
  assign res_side  = side_q;

  p_out_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_side)));

  p_start_when_idle_r9: assert property (@(posedge clk) disable iff (rst)
    start |-> (st_q == CORE_IDLE));

  p_round_in_range_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q == CORE_EXP || st_q == CORE_RUN) |-> (r_q >= ONE && r_q <= n_q));

  p_count_bounded_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q != CORE_IDLE) |-> (n_q >= ONE && n_q <= RW'(MAX_ROUNDS)));

endmodule

// File: rtl/hobf_frame_ctrl.sv
module hobf_frame_ctrl
  import hobf_pkg::*;
#(
  parameter int HR_W     = 6,
  parameter int PR_W     = 10,
  parameter int RW       = 9,
  parameter int HDR_DEF  = 8,
  parameter int HDR_MAX  = 32,
  parameter int PAY_DEF  = 8,
  parameter int PAY_MAX  = 482
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             cfg_decrypt,
  input  logic [1:0]       cfg_pad,
  input  logic [HR_W-1:0]  cfg_hdr_rounds,
  input  logic [PR_W-1:0]  cfg_pay_rounds,
  input  logic [KEY_W-1:0] psk,
  input  logic             push,
  output logic             tag_hdr,
  input  logic             buf_full,
  input  logic             buf_hdr,
  input  logic [BLK_W-1:0] buf_data,
  input  logic             core_idle,
  output logic             start,
  output logic             eng_dec,
  output logic [RW-1:0]    eng_rounds,
  output logic [KEY_W-1:0] eng_key,
  output logic [BLK_W-1:0] eng_blk,
  input  logic             res_fire,
  input  logic             res_hdr,
  input  logic [TS_W-1:0]  res_ts
);

  logic             hdr_pending;
  logic             dec_q;
  logic [1:0]       pad_q;
  logic [RW-1:0]    hdr_n_q, pay_n_q;
  logic [KEY_W-1:0] psk_q;
  logic [TS_W-1:0]  ts_q;
  logic [RW-1:0]    hdr_eff, pay_eff;

  // round counts: zero picks the default, large values saturate
  always_comb begin
    if (cfg_hdr_rounds == '0)                       hdr_eff = RW'(HDR_DEF);
    else if (cfg_hdr_rounds > HR_W'(HDR_MAX))       hdr_eff = RW'(HDR_MAX);
    else                                            hdr_eff = RW'(cfg_hdr_rounds);
    if (cfg_pay_rounds == '0)                       pay_eff = RW'(PAY_DEF);
    else if (cfg_pay_rounds > PR_W'(PAY_MAX))       pay_eff = RW'(PAY_MAX);
    else                                            pay_eff = RW'(cfg_pay_rounds);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_pending <= 1'b1;
      dec_q       <= 1'b0;
      pad_q       <= 2'd0;
      hdr_n_q     <= RW'(HDR_DEF);
      pay_n_q     <= RW'(PAY_DEF);
      psk_q       <= '0;
    end else begin
      if (frame_start) begin
        hdr_pending <= 1'b1;
        dec_q       <= cfg_decrypt;
        pad_q       <= cfg_pad;
        hdr_n_q     <= hdr_eff;
        pay_n_q     <= pay_eff;
        psk_q       <= psk;
      end else if (push) begin
        hdr_pending <= 1'b0;
      end
    end
  end

  // transmit learns the timestamp from the plaintext header,
  // receive from the deciphered one
  always_ff @(posedge clk) begin
    if (rst) begin
      ts_q <= '0;
    end else if (start && buf_hdr && !dec_q) begin
      ts_q <= buf_data[TS_W-1:0];
    end else if (res_fire && res_hdr && dec_q) begin
      ts_q <= res_ts;
    end
  end

  assign tag_hdr    = hdr_pending | frame_start;
  assign start      = buf_full & core_idle;
  assign eng_dec    = dec_q;
  assign eng_rounds = buf_hdr ? hdr_n_q : pay_n_q;
  assign eng_key    = buf_hdr ? psk_q : (psk_q ^ {{(KEY_W-TS_W){1'b0}}, ts_q});

  always_comb begin
    eng_blk = buf_data;
    if (!buf_hdr && !dec_q) begin
      if (pad_q == PAD_TWO)       eng_blk = {buf_data[BLK_W-1:16], ts_q[15:0]};
      else if (pad_q == PAD_FOUR) eng_blk = {buf_data[BLK_W-1:TS_W], ts_q};
    end
  end

endmodule

// File: rtl/hdr_obf_dp.sv
module hdr_obf_dp
  import hobf_pkg::*;
#(
  parameter int HDR_DEF_ROUNDS = 8,
  parameter int HDR_MAX_ROUNDS = 32,
  parameter int PAY_DEF_ROUNDS = 8,
  parameter int PAY_MAX_ROUNDS = 482,
  localparam int HR_W   = $clog2(HDR_MAX_ROUNDS) + 1,
  localparam int PR_W   = $clog2(PAY_MAX_ROUNDS) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              cfg_decrypt,
  input  logic [1:0]        cfg_pad,
  input  logic [HR_W-1:0]   cfg_hdr_rounds,
  input  logic [PR_W-1:0]   cfg_pay_rounds,
  input  logic [KEY_W-1:0]  psk,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FLAG_W-1:0] in_flag,
  input  logic [BLK_W-1:0]  in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FLAG_W-1:0] out_flag,
  output logic              out_hdr,
  output logic [BLK_W-1:0]  out_data
);

  localparam int RW     = $clog2(PAY_MAX_ROUNDS + 1);
  localparam int SIDE_W = 1 + FLAG_W;
  localparam int BUF_W  = SIDE_W + BLK_W;

  logic              push, tag_hdr, buf_full, core_idle, start, res_fire;
  logic [BUF_W-1:0]  buf_q;
  logic              eng_dec;
  logic [RW-1:0]     eng_rounds;
  logic [KEY_W-1:0]  eng_key;
  logic [BLK_W-1:0]  eng_blk;
  logic [SIDE_W-1:0] res_side;

  assign in_ready = ~buf_full;
  assign push     = in_valid & ~buf_full;
  assign res_fire = out_valid & out_ready;

  hobf_prefetch_buf #(.W(BUF_W)) u_buf (
    .clk  (clk),
    .rst  (rst),
    .push (push),
    .pop  (start),
    .din  ({tag_hdr, in_flag, in_data}),
    .full (buf_full),
    .dout (buf_q)
  );

  hobf_frame_ctrl #(
    .HR_W(HR_W), .PR_W(PR_W), .RW(RW),
    .HDR_DEF(HDR_DEF_ROUNDS), .HDR_MAX(HDR_MAX_ROUNDS),
    .PAY_DEF(PAY_DEF_ROUNDS), .PAY_MAX(PAY_MAX_ROUNDS)
  ) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .frame_start    (frame_start),
    .cfg_decrypt    (cfg_decrypt),
    .cfg_pad        (cfg_pad),
    .cfg_hdr_rounds (cfg_hdr_rounds),
    .cfg_pay_rounds (cfg_pay_rounds),
    .psk            (psk),
    .push           (push),
    .tag_hdr        (tag_hdr),
    .buf_full       (buf_full),
    .buf_hdr        (buf_q[BUF_W-1]),
    .buf_data       (buf_q[BLK_W-1:0]),
    .core_idle      (core_idle),
    .start          (start),
    .eng_dec        (eng_dec),
    .eng_rounds     (eng_rounds),
    .eng_key        (eng_key),
    .eng_blk        (eng_blk),
    .res_fire       (res_fire),
    .res_hdr        (out_hdr),
    .res_ts         (out_data[TS_W-1:0])
  );

  hobf_cipher_core #(
    .RW(RW), .MAX_ROUNDS(PAY_MAX_ROUNDS), .SIDE_W(SIDE_W)
  ) u_core (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .dec       (eng_dec),
    .nrounds   (eng_rounds),
    .key       (eng_key),
    .blk       (eng_blk),
    .side      (buf_q[BUF_W-1:BLK_W]),
    .idle      (core_idle),
    .res_valid (out_valid),
    .res_ready (out_ready),
    .res_data  (out_data),
    .res_side  (res_side)
  );

  assign out_hdr  = res_side[SIDE_W-1];
  assign out_flag = res_side[FLAG_W-1:0];

endmodule

// File: tb/hdr_obf_dp_test.sv
`timescale 1ns/1ps
module hdr_obf_dp_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        frame_start, cfg_decrypt;
  logic [1:0]  cfg_pad;
  logic [5:0]  cfg_hdr_rounds;
  logic [9:0]  cfg_pay_rounds;
  logic [79:0] psk;
  logic        in_valid, in_ready, out_valid, out_ready, out_hdr;
  logic [7:0]  in_flag, out_flag;
  logic [63:0] in_data, out_data;

  int n_checks = 0;
  int n_errors = 0;
  logic [72:0] exp_q[$];
  string       req_q[$];
  bit          stall = 1'b0;
  bit          bp_en = 1'b0;
  bit          last_busy;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  hdr_obf_dp uut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .cfg_decrypt(cfg_decrypt),
    .cfg_pad(cfg_pad), .cfg_hdr_rounds(cfg_hdr_rounds), .cfg_pay_rounds(cfg_pay_rounds),
    .psk(psk), .in_valid(in_valid), .in_ready(in_ready), .in_flag(in_flag),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_flag(out_flag), .out_hdr(out_hdr), .out_data(out_data)
  );

  // ---------------- reference cipher from R3 ----------------
  localparam logic [3:0] SB [16] = '{4'hC, 4'h5, 4'h6, 4'hB, 4'h9, 4'h0, 4'hA, 4'hD,
                                     4'h3, 4'hE, 4'hF, 4'h8, 4'h4, 4'h7, 4'h1, 4'h2};

  function automatic logic [63:0] m_round(logic [63:0] x);
    logic [63:0] y, o;
    for (int i = 0; i < 16; i++) y[4*i +: 4] = SB[x[4*i +: 4]];
    for (int i = 0; i < 64; i++) o[(i == 63) ? 63 : (i * 16) % 63] = y[i];
    return o;
  endfunction

  function automatic logic [63:0] m_enc(logic [63:0] p, logic [79:0] key, int n);
    logic [63:0] s = p;
    logic [79:0] k = key;
    for (int r = 1; r <= n; r++) begin
      s = m_round(s ^ k[79:16]);
      k = {k[18:0], k[79:19]};
      k[79:76] = SB[k[79:76]];
      k[23:15] = k[23:15] ^ 9'(r);
    end
    return s ^ k[79:16];
  endfunction

  function automatic int m_eff(int v, int d, int mx);
    return (v == 0) ? d : ((v > mx) ? mx : v);
  endfunction

  function automatic logic [63:0] mk_pay(int i, logic [31:0] seed);
    return {seed ^ (32'h9E37_79B9 * (i + 1)), ~seed + 32'(i * 77)};
  endfunction

  // ---------------- checking ----------------
  task automatic check(bit ok, string req, logic [72:0] act, logic [72:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compare each accepted result with the head of the scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected output", {out_hdr, out_flag, out_data}, '0);
      end else begin
        logic [72:0] e;
        string rq;
        e  = exp_q.pop_front();
        rq = req_q.pop_front();
        check({out_hdr, out_flag, out_data} === e, rq, {out_hdr, out_flag, out_data}, e);
      end
    end
  end

  // output acceptance pattern, changed just after each rising edge
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (stall)      out_ready = 1'b0;
      else if (bp_en) out_ready = lfsr[0] | lfsr[3];
      else            out_ready = 1'b1;
    end
  end

  // ---------------- driver ----------------
  task automatic push_blk(logic [7:0] flag, logic [63:0] d, logic [72:0] e, string rq);
    in_valid = 1'b1;
    in_flag  = flag;
    in_data  = d;
    while (!in_ready) @(negedge clk);
    last_busy = !out_valid;
    exp_q.push_back(e);
    req_q.push_back(rq);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic start_frame(bit dec, logic [1:0] pad, int hr, int pr, logic [79:0] key);
    cfg_decrypt    = dec;
    cfg_pad        = pad;
    cfg_hdr_rounds = 6'(hr);
    cfg_pay_rounds = 10'(pr);
    psk            = key;
    frame_start    = 1'b1;
    @(negedge clk);
    frame_start    = 1'b0;
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0 || out_valid) @(negedge clk);
  endtask

  task automatic tx_frame(logic [7:0] flag, logic [31:0] fields, logic [31:0] ts, int npay,
                          int hr, int pr, logic [1:0] pad, logic [79:0] key, string rq);
    int hn = m_eff(hr, 8, 32);
    int pn = m_eff(pr, 8, 482);
    logic [63:0] hp = {fields, ts};
    start_frame(1'b0, pad, hr, pr, key);
    push_blk(flag, hp, {1'b1, flag, m_enc(hp, key, hn)}, {"R1/R2/R3 header ", rq});
    for (int i = 0; i < npay; i++) begin
      logic [63:0] d  = mk_pay(i, ts);
      logic [63:0] pd = (pad == 2'd1) ? {d[63:16], ts[15:0]} :
                        (pad == 2'd2) ? {d[63:32], ts} : d;
      logic [7:0]  f  = 8'(i * 37 + 5);
      push_blk(f, d, {1'b0, f, m_enc(pd, key ^ {48'b0, ts}, pn)}, {"R4 payload ", rq});
    end
  endtask

  task automatic rx_frame(logic [7:0] flag, logic [31:0] fields, logic [31:0] ts, int npay,
                          int hr, int pr, logic [1:0] pad, logic [79:0] key, string rq);
    int hn = m_eff(hr, 8, 32);
    int pn = m_eff(pr, 8, 482);
    logic [63:0] hp = {fields, ts};
    start_frame(1'b1, pad, hr, pr, key);
    push_blk(flag, m_enc(hp, key, hn), {1'b1, flag, hp}, {"R7 rx header ", rq});
    for (int i = 0; i < npay; i++) begin
      logic [63:0] d = mk_pay(i, fields);
      logic [7:0]  f = 8'(i * 11 + 200);
      push_blk(f, m_enc(d, key ^ {48'b0, ts}, pn), {1'b0, f, d}, {"R7 rx payload ", rq});
    end
  endtask

  localparam logic [79:0] K1 = 80'h0F1E_2D3C_4B5A_6978_8796;
  localparam logic [79:0] K2 = 80'hA5A5_0000_FFFF_1234_C3C3;

  initial begin
    rst = 1'b1; frame_start = 1'b0; cfg_decrypt = 1'b0; cfg_pad = 2'd0;
    cfg_hdr_rounds = '0; cfg_pay_rounds = '0; psk = '0;
    in_valid = 1'b0; in_flag = '0; in_data = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R11 reset state",
          {71'b0, out_valid, in_ready}, 73'b1);

    // default counts, no padding
    tx_frame(8'hC3, 32'h2A05_1C7E, 32'h0001_F00D, 3, 0, 0, 2'd0, K1, "R5 default");
    wait_drain();
    // clamped counts, two-byte pad, random backpressure
    bp_en = 1'b1;
    tx_frame(8'h81, 32'h1111_2222, 32'hDEAD_BEEF, 2, 40, 600, 2'd1, K1, "R5 clamp R6 pad2");
    wait_drain();
    tx_frame(8'h04, 32'h7F00_3355, 32'h1234_5678, 2, 5, 16, 2'd2, K2, "R6 pad4");
    wait_drain();
    tx_frame(8'h10, 32'h0BAD_CAFE, 32'h0F0F_0F0F, 2, 1, 1, 2'd3, K2, "R6 reserved code");
    wait_drain();
    // receive direction, padding requested but ignored
    rx_frame(8'h5A, 32'h0302_0100, 32'h00C0_FFEE, 3, 8, 12, 2'd2, K1, "R6 rx ignores pad");
    wait_drain();
    rx_frame(8'hE7, 32'hFFFF_0000, 32'h8000_0001, 2, 0, 0, 2'd0, K2, "R5 rx default");
    wait_drain();
    bp_en = 1'b0;

    // R8: config changed without a frame pulse has no effect
    begin
      logic [31:0] ts = 32'h4455_6677;
      logic [63:0] hp = {32'hABCD_0123, ts};
      logic [63:0] d  = mk_pay(9, ts);
      start_frame(1'b0, 2'd0, 6, 9, K1);
      push_blk(8'h22, hp, {1'b1, 8'h22, m_enc(hp, K1, 6)}, "R8 header after pulse");
      cfg_decrypt = 1'b1; cfg_pad = 2'd2; cfg_pay_rounds = 10'd3; psk = K2;
      push_blk(8'h23, d, {1'b0, 8'h23, m_enc(d, K1 ^ {48'b0, ts}, 9)},
               "R8 config held between pulses");
      wait_drain();
      // a new pulse makes the next block a header again
      start_frame(1'b0, 2'd0, 7, 0, K2);
      push_blk(8'h24, hp, {1'b1, 8'h24, m_enc(hp, K2, 7)}, "R8 restart tags header");
      wait_drain();
    end

    // R9: payload prefetched while a long header is being enciphered
    begin
      logic [31:0] ts = 32'h0000_0A0B;
      logic [63:0] hp = {32'h9988_7766, ts};
      logic [63:0] d  = mk_pay(1, ts);
      start_frame(1'b0, 2'd0, 32, 8, K1);
      push_blk(8'h31, hp, {1'b1, 8'h31, m_enc(hp, K1, 32)}, "R9 header");
      push_blk(8'h32, d, {1'b0, 8'h32, m_enc(d, K1 ^ {48'b0, ts}, 8)}, "R9 payload");
      check(last_busy, "R9 prefetch accepted before header result", {72'b0, last_busy}, 73'b1);
      wait_drain();
    end

    // R10: result held under a stall
    begin
      logic [63:0] hp = {32'h5555_AAAA, 32'h1357_9BDF};
      logic [72:0] cap;
      stall = 1'b1;
      @(negedge clk);
      @(negedge clk);
      start_frame(1'b0, 2'd0, 3, 3, K2);
      push_blk(8'h77, hp, {1'b1, 8'h77, m_enc(hp, K2, 3)}, "R10 stalled header");
      while (!out_valid) @(negedge clk);
      cap = {out_hdr, out_flag, out_data};
      repeat (6) @(negedge clk);
      check(out_valid && {out_hdr, out_flag, out_data} === cap, "R10 output stable in stall",
            {out_hdr, out_flag, out_data}, cap);
      stall = 1'b0;
      wait_drain();
    end

    check(exp_q.size() == 0, "R1 all results delivered", 73'(exp_q.size()), 73'b0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule